// File: doc/BRIEF.md
# 8-Bit ALU with Status Flags

This block is the arithmetic and logic unit of a small 8-bit processor core, together with the processor status register it feeds. Each cycle the decoder presents an operation code, a register operand `opa` (accumulator, index register or memory value being modified) and a second operand `opb` (memory or immediate value). The unit produces a result combinationally and, on the rising clock edge with `op_valid` high, changes only the status flags that the chosen operation is defined to affect. All other flags keep their values.

The status register also serves the stack path. A pull operation loads it from `opb`. The two push operations return the status byte in the format used on the stack, with the break bit set for a software push and cleared for a hardware interrupt. Decimal arithmetic, instruction decode and bus access are not part of the block. The decimal flag is only stored.

Top module: `alu8_status`

## Requirements
- R1: The status port is laid out N(7) V(6) one(5) B(4) D(3) I(2) Z(1) C(0). Bit 5 always reads 1 and bit 4 always reads 0. After reset the status is 0x24, which means only I is set. The status changes only on a rising clock edge with `op_valid` high. With `op_valid` low it holds its value, whatever the other inputs are.
- R2: Operation codes: 0 add-with-carry, 1 subtract-with-carry, 2 and, 3 or, 4 xor, 5 shift-left, 6 shift-right, 7 rotate-left, 8 rotate-right, 9 increment, 10 decrement, 11 compare, 12 bit-test, 13 clear-C, 14 set-C, 15 clear-I, 16 set-I, 17 clear-D, 18 set-D, 19 clear-V, 20 pull-status, 21 load, 22 transfer-to-stack-pointer, 23 software-push, 24 hardware-push. Codes 25 to 31 do nothing: the result is 0, `res_wr` is low and no flag changes.
- R3: Add gives `opa + opb + C` modulo 256. C is set to the carry out. V is set when the signed sum lies outside -128..127. N is set to result bit 7, and Z is set when the result is zero.
- R4: Subtract gives `opa - opb - (1 - C)` modulo 256. C is set when no borrow occurred, meaning the unsigned difference is not negative. V is set when the signed difference lies outside -128..127. N and Z follow the result.
- R5: And, or, xor, increment and decrement write the 8-bit result and update only N and Z. V, D, I and C are left unchanged.
- R6: The four shifts and rotates act on `opa` and update N, Z and C. The bit shifted out goes to C. Shift-left fills bit 0 with 0 and shift-right fills bit 7 with 0. Rotate-left fills bit 0 with the old C, and rotate-right fills bit 7 with the old C.
- R7: Compare sets C when `opa >= opb` unsigned, sets Z when the two are equal, and sets N to bit 7 of `opa - opb`. It writes no result and leaves V, D and I unchanged.
- R8: Bit-test sets N to `opb` bit 7 and V to `opb` bit 6. It sets Z when `opa AND opb` is zero. It writes no result and leaves D, I and C unchanged.
- R9: Each of the seven flag operations changes only its own flag, to the stated value, and writes no result.
- R10: Pull-status copies `opb` bits 7, 6, 3, 2, 1 and 0 into N, V, D, I, Z and C, ignores `opb` bits 5 and 4, and writes no result. Load writes `opb` as the result and updates N and Z. Transfer-to-stack-pointer writes `opb` as the result and changes no flag.
- R11: Software-push writes the current status with bits 5 and 4 both 1. Hardware-push writes it with bit 5 at 1 and bit 4 at 0. Neither changes a flag.
- R12: `res_wr` is high exactly when `op_valid` is high and the operation writes a result (codes 0 to 10 and 21 to 24). The result is 0 for every operation that writes none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | The operation on the inputs executes this cycle |
| op_code | input | 5 | Operation selector (R2) |
| opa | input | 8 | Register operand |
| opb | input | 8 | Memory / immediate operand |
| result | output | 8 | Combinational result |
| res_wr | output | 1 | The result is to be written back |
| status | output | 8 | Status register |

## Verification
The assertions assume that the operation code and operands are stable and known around each rising edge. They also assume that flag checks apply only in the cycle after an accepted operation, so they read `$past` only of values sampled while reset was released. The stimulus changes inputs only on falling edges. It uses codes from the full 5-bit range, including the unused ones, and drives cycles with `op_valid` low while live operands sit on the inputs. A behavioural model, built on signed and unsigned integer arithmetic, predicts the result on every cycle and the status after every edge.

// File: rtl/alu8_pkg.sv
// Shared definitions for the 8-bit ALU: operation codes and status bit positions.
// Assumes an 8-bit status register. The bit positions are architectural.
package alu8_pkg;
    typedef enum logic [4:0] {
        OP_ADC  = 5'd0,  OP_SBC  = 5'd1,  OP_AND  = 5'd2,  OP_ORA  = 5'd3,
        OP_EOR  = 5'd4,  OP_ASL  = 5'd5,  OP_LSR  = 5'd6,  OP_ROL  = 5'd7,
        OP_ROR  = 5'd8,  OP_INC  = 5'd9,  OP_DEC  = 5'd10, OP_CMP  = 5'd11,
        OP_BIT  = 5'd12, OP_CLC  = 5'd13, OP_SEC  = 5'd14, OP_CLI  = 5'd15,
        OP_SEI  = 5'd16, OP_CLD  = 5'd17, OP_SED  = 5'd18, OP_CLV  = 5'd19,
        OP_PULL = 5'd20, OP_LOAD = 5'd21, OP_TXS  = 5'd22, OP_PSHS = 5'd23,
        OP_PSHH = 5'd24
    } alu_op_e;

    localparam int FN = 7;
    localparam int FV = 6;
    localparam int FU = 5;
    localparam int FB = 4;
    localparam int FD = 3;
    localparam int FI = 2;
    localparam int FZ = 1;
    localparam int FC = 0;
    localparam int SW = 8;
    localparam logic [SW-1:0] ST_FORCE1 = 8'h20;
    localparam logic [SW-1:0] ST_FORCE0 = 8'h10;
    localparam logic [SW-1:0] ST_RESET  = 8'h24;
endpackage

// File: rtl/alu8_adder.sv
// Shared adder for add, subtract and compare. When inv is set it adds the
// one's complement of b, so carry out means "no borrow".
// Assumes DW >= 2.
module alu8_adder #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          inv,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          ovf
);
    localparam int MSB = DW - 1;
    logic [DW-1:0] bi;

    // Add with optional complement and derive the signed overflow.
    always_comb begin
        bi          = inv ? ~b : b;
        {cout, sum} = {1'b0, a} + {1'b0, bi} + {{DW{1'b0}}, cin};
        ovf         = (a[MSB] == bi[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu8_core.sv
// Combinational operation unit. It produces the result and write flag, plus
// a per-flag update mask and the new flag values. It holds no state and
// assumes flags_i is the current status.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [SW-1:0] flags_i,
    output logic [DW-1:0] res,
    output logic          writes,
    output logic [SW-1:0] upd_mask,
    output logic [SW-1:0] upd_val
);
    localparam int MSB = DW - 1;
    logic [DW-1:0] sum;
    logic          cout, ovf, add_inv, add_cin, sh_c;
    logic [SW-1:0] push_sw, push_hw;

    // Operand setup for the shared adder.
    always_comb begin
        add_inv = (op != OP_ADC);
        add_cin = (op == OP_CMP) ? 1'b1 : flags_i[FC];
    end

    alu8_adder #(.DW(DW)) i_add (
        .a(a), .b(b), .inv(add_inv), .cin(add_cin),
        .sum(sum), .cout(cout), .ovf(ovf)
    );

    // Stack images of the status byte.
    always_comb begin
        push_sw = flags_i | ST_FORCE1 | ST_FORCE0;
        push_hw = (flags_i | ST_FORCE1) & ~ST_FORCE0;
    end

    // Result value, write flag and the bit shifted out.
    always_comb begin
        res    = '0;
        writes = 1'b0;
        sh_c   = 1'b0;
        unique case (op)
            OP_ADC, OP_SBC: begin res = sum;   writes = 1'b1; end
            OP_AND:  begin res = a & b;        writes = 1'b1; end
            OP_ORA:  begin res = a | b;        writes = 1'b1; end
            OP_EOR:  begin res = a ^ b;        writes = 1'b1; end
            OP_ASL:  begin res = {a[MSB-1:0], 1'b0};         sh_c = a[MSB]; writes = 1'b1; end
            OP_LSR:  begin res = {1'b0, a[MSB:1]};           sh_c = a[0];   writes = 1'b1; end
            OP_ROL:  begin res = {a[MSB-1:0], flags_i[FC]};  sh_c = a[MSB]; writes = 1'b1; end
            OP_ROR:  begin res = {flags_i[FC], a[MSB:1]};    sh_c = a[0];   writes = 1'b1; end
            OP_INC:  begin res = a + 1'b1;     writes = 1'b1; end
            OP_DEC:  begin res = a - 1'b1;     writes = 1'b1; end
            OP_LOAD, OP_TXS: begin res = b;    writes = 1'b1; end
            OP_PSHS: begin res = DW'(push_sw); writes = 1'b1; end
            OP_PSHH: begin res = DW'(push_hw); writes = 1'b1; end
            default: ;
        endcase
    end

    // Which flags change and to what.
    always_comb begin
        upd_mask = '0;
        upd_val  = '0;
        upd_val[FN] = res[MSB];
        upd_val[FZ] = (res == '0);
        unique case (op)
            OP_ADC, OP_SBC: begin
                upd_mask[FN] = 1'b1; upd_mask[FZ] = 1'b1;
                upd_mask[FV] = 1'b1; upd_mask[FC] = 1'b1;
                upd_val[FV]  = ovf;  upd_val[FC]  = cout;
            end
            OP_AND, OP_ORA, OP_EOR, OP_INC, OP_DEC, OP_LOAD: begin
                upd_mask[FN] = 1'b1; upd_mask[FZ] = 1'b1;
            end
            OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
                upd_mask[FN] = 1'b1; upd_mask[FZ] = 1'b1; upd_mask[FC] = 1'b1;
                upd_val[FC]  = sh_c;
            end
            OP_CMP: begin
                upd_mask[FN] = 1'b1; upd_mask[FZ] = 1'b1; upd_mask[FC] = 1'b1;
                upd_val[FN]  = sum[MSB];
                upd_val[FZ]  = (sum == '0);
                upd_val[FC]  = cout;
            end
            OP_BIT: begin
                upd_mask[FN] = 1'b1; upd_mask[FV] = 1'b1; upd_mask[FZ] = 1'b1;
                upd_val[FN]  = b[MSB];
                upd_val[FV]  = b[MSB-1];
                upd_val[FZ]  = ((a & b) == '0);
            end
            OP_CLC: begin upd_mask[FC] = 1'b1; upd_val[FC] = 1'b0; end
            OP_SEC: begin upd_mask[FC] = 1'b1; upd_val[FC] = 1'b1; end
            OP_CLI: begin upd_mask[FI] = 1'b1; upd_val[FI] = 1'b0; end
            OP_SEI: begin upd_mask[FI] = 1'b1; upd_val[FI] = 1'b1; end
            OP_CLD: begin upd_mask[FD] = 1'b1; upd_val[FD] = 1'b0; end
            OP_SED: begin upd_mask[FD] = 1'b1; upd_val[FD] = 1'b1; end
            OP_CLV: begin upd_mask[FV] = 1'b1; upd_val[FV] = 1'b0; end
            OP_PULL: begin
                upd_mask = ~(ST_FORCE1 | ST_FORCE0);
                upd_val  = SW'(b);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_flagreg.sv
// Status register with a per-bit update mask. The constant bits are forced
// on every load. Assumes the mask is meaningful only when en is high.
module alu8_flagreg
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [SW-1:0] mask,
    input  logic [SW-1:0] val,
    output logic [SW-1:0] q
);
    logic [SW-1:0] nxt;

    // Merge the new flag values into the held ones.
    always_comb nxt = (q & ~mask) | (val & mask);

    // Register the status, with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= ST_RESET;
        else if (en) q <= (nxt | ST_FORCE1) & ~ST_FORCE0;
    end
endmodule

// File: rtl/alu8_status.sv
// Top level: combinational ALU with a registered status register. Flags
// update on the rising edge when op_valid is high. Assumes the inputs are
// stable around the edge.
module alu8_status
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [4:0]    op_code,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] result,
    output logic          res_wr,
    output logic [SW-1:0] status
);
    logic          writes;
    logic [SW-1:0] mask, val;
    alu_op_e       op;

    // Map the raw code onto the operation type.
    always_comb op = alu_op_e'(op_code);

    alu8_core #(.DW(DW)) i_core (
        .op(op), .a(opa), .b(opb), .flags_i(status),
        .res(result), .writes(writes), .upd_mask(mask), .upd_val(val)
    );

    alu8_flagreg i_flags (
        .clk(clk), .rst_n(rst_n), .en(op_valid),
        .mask(mask), .val(val), .q(status)
    );

    // Write-back strobe for the result.
    always_comb res_wr = op_valid && writes;
endmodule

// File: rtl/alu8_status_chk.sv
// Port-level assertions for alu8_status. They are attached with bind.
module alu8_status_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [4:0]    op_code,
    input logic [DW-1:0] opa,
    input logic [DW-1:0] opb,
    input logic [DW-1:0] result,
    input logic          res_wr,
    input logic [7:0]    status
);
    localparam int MSB = DW - 1;

    p_const_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status[5] && !status[4]);

    p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> status == $past(status));

    p_logic_keeps_vdic_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code inside {5'd2, 5'd3, 5'd4, 5'd9, 5'd10})
        |=> {status[6], status[3], status[2], status[0]} ==
            {$past(status[6]), $past(status[3]), $past(status[2]), $past(status[0])});

    p_logic_z_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code inside {5'd2, 5'd3, 5'd4, 5'd9, 5'd10})
        |=> status[1] == ($past(result) == '0));

    p_cmp_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code inside {5'd11, 5'd12}) |-> !res_wr);

    p_bit_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == 5'd12
        |=> status[7] == $past(opb[MSB]) && status[6] == $past(opb[MSB-1])
            && status[1] == ($past(opa & opb) == '0));

    p_txs_no_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == 5'd22 |=> status == $past(status));

    p_push_format_r11: assert property (@(posedge clk) disable iff (!rst_n)
        op_code == 5'd23 |-> result[5:4] == 2'b11);

    p_push_hw_format_r11: assert property (@(posedge clk) disable iff (!rst_n)
        op_code == 5'd24 |-> result[5:4] == 2'b10);

    p_wr_needs_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr |-> op_valid);
endmodule

bind alu8_status alu8_status_chk #(.DW(DW)) i_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opa(opa), .opb(opb), .result(result), .res_wr(res_wr), .status(status)
);

// File: tb/test_alu8_status.sv
// Bench for alu8_status. A behavioural integer model predicts the result each
// cycle and the status after each edge.
module test_alu8_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_code = '0;
    logic [7:0] opa = '0, opb = '0;
    logic [7:0] result, status;
    logic       res_wr;

    int checks = 0, failures = 0;
    int m_st = 8'h24;

    always #10 clk = ~clk;

    alu8_status i_alu8_status (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opa(opa), .opb(opb), .result(result), .res_wr(res_wr), .status(status)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int sgn(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    // Behavioural model: returns {write, result}; updates st by reference.
    function automatic int model(input int op, input int a, input int b,
                                 input bit valid, ref int st);
        int n, v, d, i, z, c, r, w, t, s;
        n = (st >> 7) & 1; v = (st >> 6) & 1; d = (st >> 3) & 1;
        i = (st >> 2) & 1; z = (st >> 1) & 1; c = st & 1;
        r = 0; w = 0;
        case (op)
            0: begin t = a + b + c; s = sgn(a) + sgn(b) + c; r = t & 255; w = 1;
                     c = (t > 255); v = (s > 127 || s < -128); end
            1: begin t = a - b - (1 - c); s = sgn(a) - sgn(b) - (1 - c); r = t & 255; w = 1;
                     c = (t >= 0); v = (s > 127 || s < -128); end
            2: begin r = a & b; w = 1; end
            3: begin r = a | b; w = 1; end
            4: begin r = a ^ b; w = 1; end
            5: begin r = (a * 2) & 255; w = 1; c = a / 128; end
            6: begin r = a / 2; w = 1; c = a % 2; end
            7: begin r = ((a * 2) & 255) + c; w = 1; c = a / 128; end
            8: begin r = a / 2 + c * 128; w = 1; c = a % 2; end
            9: begin r = (a + 1) & 255; w = 1; end
            10: begin r = (a + 255) & 255; w = 1; end
            11: begin t = (a - b) & 255; n = t / 128; z = (a == b); c = (a >= b); end
            12: begin n = b / 128; v = (b / 64) % 2; z = ((a & b) == 0); end
            13: c = 0; 14: c = 1; 15: i = 0; 16: i = 1;
            17: d = 0; 18: d = 1; 19: v = 0;
            20: begin n = (b >> 7) & 1; v = (b >> 6) & 1; d = (b >> 3) & 1;
                      i = (b >> 2) & 1; z = (b >> 1) & 1; c = b & 1; end
            21: begin r = b; w = 1; end
            22: begin r = b; w = 1; end
            23: begin r = st | 8'h30; w = 1; end
            24: begin r = st | 8'h20; w = 1; end
            default: ;
        endcase
        if (op inside {[0:10], 21}) begin n = r / 128; z = (r == 0); end
        if (valid) st = n * 128 + v * 64 + 32 + d * 8 + i * 4 + z * 2 + c;
        return (w * 256) + r;
    endfunction

    // Apply one operation; check the combinational outputs, then the status.
    task automatic do_op(input int op, input int a, input int b, input bit valid,
                         input string req);
        int e;
        @(negedge clk);
        op_code = op[4:0]; opa = a[7:0]; opb = b[7:0]; op_valid = valid;
        #5;
        e = model(op, a, b, valid, m_st);
        check({req, " result"}, int'(result), e & 255);
        check({req, " res_wr"}, int'(res_wr), valid ? (e >> 8) : 0);
        @(posedge clk); #1;
        check({req, " status"}, int'(status), m_st);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset status", int'(status), 8'h24);
        @(negedge clk); rst_n = 1'b1;
        // R3: add, including signed overflow and carry out.
        do_op(14, 0, 0, 1, "R9 sec");
        do_op(0, 8'h50, 8'h50, 1, "R3 adc ovf");
        do_op(0, 8'hFF, 8'h01, 1, "R3 adc carry zero");
        // R4: subtract with borrow and without.
        do_op(1, 8'h10, 8'h20, 1, "R4 sbc borrow");
        do_op(1, 8'h80, 8'h01, 1, "R4 sbc ovf");
        // R5: logic, increment and decrement.
        do_op(2, 8'hF0, 8'h0F, 1, "R5 and zero");
        do_op(3, 8'h80, 8'h01, 1, "R5 ora neg");
        do_op(4, 8'hAA, 8'hAA, 1, "R5 eor");
        do_op(9, 8'hFF, 0, 1, "R5 inc wrap");
        do_op(10, 8'h00, 0, 1, "R5 dec wrap");
        // R6: shifts and rotates through carry.
        do_op(14, 0, 0, 1, "R9 sec");
        do_op(7, 8'h80, 0, 1, "R6 rol");
        do_op(8, 8'h01, 0, 1, "R6 ror");
        do_op(5, 8'h81, 0, 1, "R6 asl");
        do_op(6, 8'h01, 0, 1, "R6 lsr");
        // R7 and R8.
        do_op(11, 8'h40, 8'h40, 1, "R7 cmp equal");
        do_op(11, 8'h10, 8'h20, 1, "R7 cmp less");
        do_op(12, 8'h01, 8'hC0, 1, "R8 bit");
        // R9: flag operations.
        for (int k = 13; k <= 19; k++) do_op(k, 8'hFF, 8'hFF, 1, "R9 flag op");
        // R10: pull, load, transfer.
        do_op(20, 0, 8'hFF, 1, "R10 pull all ones");
        do_op(21, 0, 8'h00, 1, "R10 load zero");
        do_op(22, 0, 8'h80, 1, "R10 txs");
        do_op(20, 0, 8'h30, 1, "R10 pull ignores 5 4");
        // R11: push formats.
        do_op(23, 0, 0, 1, "R11 push sw");
        do_op(24, 0, 0, 1, "R11 push hw");
        // R2 and R12: unused codes, and valid low with live operands.
        for (int k = 25; k <= 31; k++) do_op(k, 8'h12, 8'h34, 1, "R2 unused code");
        do_op(0, 8'h7F, 8'h7F, 0, "R1 R12 idle adc");
        do_op(20, 0, 8'h00, 0, "R1 idle pull");
        // Mixed random traffic across the whole code range.
        for (int k = 0; k < 600; k++)
            do_op(int'($urandom_range(31)), int'($urandom_range(255)),
                  int'($urandom_range(255)), ($urandom_range(7) != 0), "R2 random");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule